// File: doc/BRIEF.md
# Path Metric Store with Minimum Finder

This block holds the accumulated path metrics of a four-state trellis decoder across a window of eight time snapshots. Each snapshot is a bank of four 4-bit entries, one per state. The add-compare-select logic writes one updated metric per clock, addressed by snapshot and state. In the same clock it can fetch two stored metrics through a pair of read ports that share one read enable. Read data is registered, so it appears one clock after the request. When a read and a write hit the same entry in the same clock, the read returns the newly written value.

Reset and a synchronous clear both put the store into its start condition. Snapshot 0 holds 0 for state 0 and 7 for states 1 to 3, so that a metric which starts out unlikely can still grow without wrapping. Every other entry is 0. The controller asserts the clear after each full traceback window.

A separate combinational search takes four metrics straight from an input bus, not from storage. It reports the smallest value and the state that owns it. On a tie it reports the lowest-numbered state, so traceback always starts from exactly one state.

Top module: `pm_store`

## Requirements
- R1: After reset, and on the clock after `clr_i` is high, entry (snapshot 0, state 0) reads 0, entries (snapshot 0, states 1..3) read 7, and every other entry reads 0. Both read outputs are 0 straight after reset.
- R2: When `wr_en_i` is high and `wr_slot_i` is 0..7, the clock edge stores `wr_data_i` at entry (`wr_slot_i`, `wr_state_i`). Later reads of that entry return the stored value.
- R3: When `rd_en_i` is high at a clock edge, both read ports load the entries at their own (slot, state) addresses. The values are visible on `rd_a_data_o` and `rd_b_data_o` after that edge.
- R4: While `rd_en_i` is low, both read outputs keep their values, even if the read addresses change or the entries are written.
- R5: A read in the same clock as an accepted write to the same (slot, state) returns the written data, on either port.
- R6: A write whose `wr_slot_i` is 8 to 15 changes no entry.
- R7: When `clr_i` and `wr_en_i` are high in the same clock, the clear wins and the write is dropped.
- R8: `min_val_o` is the smallest of the four metrics on `cand_i`, where the metric of state k sits in bits [4k+3:4k]. `min_state_o` is the state of that metric. Both follow `cand_i` with no clock edge in between.
- R9: When several states share the minimum, `min_state_o` is the lowest-numbered of them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr_i | input | 1 | Synchronous clear back to the start condition |
| wr_en_i | input | 1 | Write request |
| wr_slot_i | input | 4 | Write snapshot index (8..15 ignored) |
| wr_state_i | input | 2 | Write state index |
| wr_data_i | input | 4 | Metric to store |
| rd_en_i | input | 1 | Read request for both ports |
| rd_a_slot_i | input | 3 | Port A snapshot index |
| rd_a_state_i | input | 2 | Port A state index |
| rd_b_slot_i | input | 3 | Port B snapshot index |
| rd_b_state_i | input | 2 | Port B state index |
| rd_a_data_o | output | 4 | Port A registered read data |
| rd_b_data_o | output | 4 | Port B registered read data |
| cand_i | input | 16 | Four metrics for the minimum search, state k at [4k+3:4k] |
| min_state_o | output | 2 | State holding the smallest metric |
| min_val_o | output | 4 | Smallest metric |

## Verification
The store is read out in full after reset, after a burst of writes, after writes to out-of-range snapshots, and after a clear that coincides with a write. Comparing each full read-out with the start condition shows whether a preset, a dropped write or a priority rule is wrong. Reads aimed at the entry being written show whether forwarding works on each port, and a quiet read enable shows whether the outputs hold. The minimum search is given a distinct minimum at different positions, all-equal metrics, a tie between two middle states, and the extreme values 0 and 15. This separates a wrong comparison from a wrong tie rule.

// File: rtl/pm_store.sv
`timescale 1ns/1ps
module pm_store #(
  parameter int NUM_STATES = 4,
  parameter int METRIC_W   = 4,
  parameter int NUM_SLOTS  = 8,
  parameter int START_HIGH = 7
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           clr_i,
  input  logic                           wr_en_i,
  input  logic [$clog2(NUM_SLOTS):0]     wr_slot_i,
  input  logic [$clog2(NUM_STATES)-1:0]  wr_state_i,
  input  logic [METRIC_W-1:0]            wr_data_i,
  input  logic                           rd_en_i,
  input  logic [$clog2(NUM_SLOTS)-1:0]   rd_a_slot_i,
  input  logic [$clog2(NUM_STATES)-1:0]  rd_a_state_i,
  input  logic [$clog2(NUM_SLOTS)-1:0]   rd_b_slot_i,
  input  logic [$clog2(NUM_STATES)-1:0]  rd_b_state_i,
  output logic [METRIC_W-1:0]            rd_a_data_o,
  output logic [METRIC_W-1:0]            rd_b_data_o,
  input  logic [NUM_STATES*METRIC_W-1:0] cand_i,
  output logic [$clog2(NUM_STATES)-1:0]  min_state_o,
  output logic [METRIC_W-1:0]            min_val_o
);
  localparam int ST_W    = $clog2(NUM_STATES);
  localparam int SL_W    = $clog2(NUM_SLOTS);
  localparam int WS_W    = SL_W + 1;
  localparam int ENTRIES = NUM_SLOTS * NUM_STATES;
  localparam int ADDR_W  = $clog2(ENTRIES);

  function automatic logic [METRIC_W-1:0] start_val(int idx);
    if (idx == 0)               return '0;
    else if (idx < NUM_STATES)  return METRIC_W'(START_HIGH);
    else                        return '0;
  endfunction

  logic [METRIC_W-1:0] mem_q [ENTRIES];

  logic              wr_ok;
  logic [ADDR_W-1:0] wr_idx, a_idx, b_idx;
  logic              a_hit, b_hit;

  assign wr_ok  = wr_en_i && (wr_slot_i < WS_W'(NUM_SLOTS));
  assign wr_idx = ADDR_W'(int'(wr_slot_i[SL_W-1:0]) * NUM_STATES + int'(wr_state_i));
  assign a_idx  = ADDR_W'(int'(rd_a_slot_i) * NUM_STATES + int'(rd_a_state_i));
  assign b_idx  = ADDR_W'(int'(rd_b_slot_i) * NUM_STATES + int'(rd_b_state_i));
  assign a_hit  = wr_ok && !clr_i && (wr_idx == a_idx);
  assign b_hit  = wr_ok && !clr_i && (wr_idx == b_idx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) mem_q[i] <= start_val(i);
    end else if (clr_i) begin
      for (int i = 0; i < ENTRIES; i++) mem_q[i] <= start_val(i);
    end else if (wr_ok) begin
      mem_q[wr_idx] <= wr_data_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_a_data_o <= '0;
      rd_b_data_o <= '0;
    end else if (rd_en_i) begin
      rd_a_data_o <= a_hit ? wr_data_i : mem_q[a_idx];
      rd_b_data_o <= b_hit ? wr_data_i : mem_q[b_idx];
    end
  end

  always_comb begin
    min_val_o   = cand_i[METRIC_W-1:0];
    min_state_o = '0;
    for (int k = 1; k < NUM_STATES; k++) begin
      if (cand_i[k*METRIC_W +: METRIC_W] < min_val_o) begin
        min_val_o   = cand_i[k*METRIC_W +: METRIC_W];
        min_state_o = ST_W'(k);
      end
    end
  end

  assert_hold_a_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en_i |=> $stable(rd_a_data_o));
  assert_hold_b_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en_i |=> $stable(rd_b_data_o));

  assert_fwd_a_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en_i && wr_en_i && !clr_i && wr_slot_i == {1'b0, rd_a_slot_i} &&
     wr_state_i == rd_a_state_i) |=> rd_a_data_o == $past(wr_data_i));

  assert_min_owned_R8: assert property (@(posedge clk) disable iff (!rst_n)
    min_val_o == cand_i[min_state_o*METRIC_W +: METRIC_W]);

  for (genvar k = 0; k < NUM_STATES; k++) begin : g_min_chk
    assert_min_le_R8: assert property (@(posedge clk) disable iff (!rst_n)
      min_val_o <= cand_i[k*METRIC_W +: METRIC_W]);
    assert_tie_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (ST_W'(k) < min_state_o) |-> (cand_i[k*METRIC_W +: METRIC_W] > min_val_o));
  end
endmodule

// File: tb/pm_store_tb_top.sv
`timescale 1ns/1ps
module pm_store_tb_top;
  logic clk = 0, rst_n = 0, clr_i = 0, wr_en_i = 0, rd_en_i = 0;
  logic [3:0] wr_slot_i = 0;
  logic [1:0] wr_state_i = 0, rd_a_state_i = 0, rd_b_state_i = 0;
  logic [3:0] wr_data_i = 0;
  logic [2:0] rd_a_slot_i = 0, rd_b_slot_i = 0;
  logic [3:0] rd_a_data_o, rd_b_data_o, min_val_o;
  logic [15:0] cand_i = 0;
  logic [1:0] min_state_o;

  int checks = 0, errors = 0;
  bit done = 0;
  int ref_m [32];

  always #2.5 clk = ~clk;

  pm_store dut_i (
    .clk(clk), .rst_n(rst_n), .clr_i(clr_i), .wr_en_i(wr_en_i),
    .wr_slot_i(wr_slot_i), .wr_state_i(wr_state_i), .wr_data_i(wr_data_i),
    .rd_en_i(rd_en_i), .rd_a_slot_i(rd_a_slot_i), .rd_a_state_i(rd_a_state_i),
    .rd_b_slot_i(rd_b_slot_i), .rd_b_state_i(rd_b_state_i),
    .rd_a_data_o(rd_a_data_o), .rd_b_data_o(rd_b_data_o),
    .cand_i(cand_i), .min_state_o(min_state_o), .min_val_o(min_val_o));

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic model_preset();
    for (int i = 0; i < 32; i++) ref_m[i] = (i >= 1 && i <= 3) ? 7 : 0;
  endtask

  task automatic wr(int slot, int st, int d);
    @(negedge clk);
    wr_en_i = 1; wr_slot_i = 4'(slot); wr_state_i = 2'(st); wr_data_i = 4'(d);
    @(posedge clk); #1;
    wr_en_i = 0;
    if (slot < 8) ref_m[slot*4+st] = d;
  endtask

  task automatic rd(string tag, int ia, int ib);
    @(negedge clk);
    rd_en_i = 1;
    rd_a_slot_i = 3'(ia / 4); rd_a_state_i = 2'(ia % 4);
    rd_b_slot_i = 3'(ib / 4); rd_b_state_i = 2'(ib % 4);
    @(posedge clk); #1;
    rd_en_i = 0;
    chk({tag, " port A"}, rd_a_data_o, ref_m[ia]);
    chk({tag, " port B"}, rd_b_data_o, ref_m[ib]);
  endtask

  task automatic read_all(string tag);
    for (int i = 0; i < 32; i++) rd(tag, i, (i + 13) % 32);
  endtask

  task automatic test_reset_R1();
    chk("R1 reset port A zero", rd_a_data_o, 0);
    chk("R1 reset port B zero", rd_b_data_o, 0);
    read_all("R1 preset after reset");
  endtask

  task automatic test_write_R2_R3();
    wr(0, 0, 3); wr(7, 3, 15); wr(3, 2, 9); wr(5, 1, 4); wr(0, 2, 1);
    rd("R2 written entry", 24+7, 3*4+2);
    rd("R3 two ports distinct", 5*4+1, 0);
    rd("R3 same entry both", 2, 2);
    read_all("R2 full readback");
  endtask

  task automatic test_hold_R4();
    logic [3:0] a0, b0;
    rd("R4 setup", 3*4+2, 5*4+1);
    a0 = rd_a_data_o; b0 = rd_b_data_o;
    @(negedge clk);
    rd_a_slot_i = 3'd7; rd_a_state_i = 2'd3; rd_b_slot_i = 3'd0; rd_b_state_i = 2'd1;
    wr_en_i = 1; wr_slot_i = 4'd3; wr_state_i = 2'd2; wr_data_i = 4'd12;
    @(posedge clk); #1;
    wr_en_i = 0; ref_m[3*4+2] = 12;
    @(posedge clk); #1;
    chk("R4 port A held", rd_a_data_o, a0);
    chk("R4 port B held", rd_b_data_o, b0);
  endtask

  task automatic test_fwd_R5();
    @(negedge clk);
    wr_en_i = 1; wr_slot_i = 4'd4; wr_state_i = 2'd2; wr_data_i = 4'd10;
    rd_en_i = 1; rd_a_slot_i = 3'd4; rd_a_state_i = 2'd2;
    rd_b_slot_i = 3'd4; rd_b_state_i = 2'd2;
    @(posedge clk); #1;
    wr_en_i = 0; rd_en_i = 0; ref_m[4*4+2] = 10;
    chk("R5 forward port A", rd_a_data_o, 10);
    chk("R5 forward port B", rd_b_data_o, 10);
    @(negedge clk);
    wr_en_i = 1; wr_slot_i = 4'd6; wr_state_i = 2'd0; wr_data_i = 4'd5;
    rd_en_i = 1; rd_a_slot_i = 3'd1; rd_a_state_i = 2'd1;
    rd_b_slot_i = 3'd6; rd_b_state_i = 2'd0;
    @(posedge clk); #1;
    wr_en_i = 0; rd_en_i = 0; ref_m[6*4] = 5;
    chk("R5 unrelated port A", rd_a_data_o, ref_m[5]);
    chk("R5 forward port B only", rd_b_data_o, 5);
  endtask

  task automatic test_bad_slot_R6();
    for (int s = 8; s < 16; s++) wr(s, s % 4, 14);
    read_all("R6 out-of-range write ignored");
  endtask

  task automatic test_clear_R7();
    @(negedge clk);
    clr_i = 1; wr_en_i = 1; wr_slot_i = 4'd3; wr_state_i = 2'd1; wr_data_i = 4'd11;
    @(posedge clk); #1;
    clr_i = 0; wr_en_i = 0;
    model_preset();
    read_all("R7 clear beats write R1");
  endtask

  task automatic mn(string tag, int c0, int c1, int c2, int c3, int es, int ev);
    cand_i = {4'(c3), 4'(c2), 4'(c1), 4'(c0)};
    #1;
    chk({tag, " state"}, min_state_o, es);
    chk({tag, " value"}, min_val_o, ev);
  endtask

  task automatic test_min_R8_R9();
    mn("R8 distinct min at S2", 3, 9, 1, 5, 2, 1);
    mn("R8 zero at S3", 8, 4, 2, 0, 3, 0);
    mn("R8 min at S1", 15, 2, 7, 3, 1, 2);
    mn("R9 all equal", 6, 6, 6, 6, 0, 6);
    mn("R9 S1 S3 tie", 9, 2, 5, 2, 1, 2);
    mn("R9 all max", 15, 15, 15, 15, 0, 15);
    mn("R9 S2 S3 tie", 12, 11, 4, 4, 2, 4);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    model_preset();
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    test_reset_R1();
    test_write_R2_R3();
    test_hold_R4();
    test_fwd_R5();
    test_bad_slot_R6();
    test_clear_R7();
    test_min_R8_R9();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule